// File: doc/BRIEF.md
# Firmware Bus Single-Byte Read Initiator

This block is the host-side master for single-byte memory reads on a 4-bit multiplexed firmware bus. A client raises a one-clock request with a 4-bit device select and a 28-bit byte address. The block then runs the whole bus cycle. It sends a start code with the frame line low, then the select nibble, the address nibbles and a single-byte size code. It drives a turnaround and hands the bus to the target. It waits for a ready sync and captures the data byte, which arrives low nibble first. It lets the target hand the bus back, then reports the byte with a one-clock done pulse.

The bus pins are split into an input nibble, an output nibble and an output enable for a pad cell. The host drives all ones on the bus whenever it owns it and is idle. Non-ready sync nibbles are taken as wait states. If no ready sync arrives within a bounded number of clocks, the block abandons the cycle, keeps the bus released for one clock, and reports done with a timeout flag.

Top module: `fwb_read_init`

## Requirements
- R1: During and after reset, before any request, frame_no is 1, bus_oe_o is 1, bus_o is 4'b1111, and done_o and timeout_o are 0; the host keeps this idle bus state whenever no cycle runs.
- R2: A request taken in idle makes the next clock the start clock: frame_no is 0 and bus_o is 4'b1101 with bus_oe_o 1. frame_no is 1 in every other clock.
- R3: The clock after the start clock carries the latched 4-bit device select on bus_o.
- R4: The next seven clocks carry the latched 28-bit address, one nibble per clock, bits [27:24] first and bits [3:0] last.
- R5: The clock after the last address nibble carries the size code 4'b0000.
- R6: The next clock drives 4'b1111 with bus_oe_o 1 (first turnaround). In the clock after it bus_oe_o is 0 (second turnaround).
- R7: From the clock after the second turnaround, bus_i is sampled once per clock as a sync code, with bus_oe_o held at 0. The value 4'b0000 means ready; any other value is a wait. After a ready sync, the next clock's bus_i is data bits [3:0] and the clock after that gives bits [7:4].
- R8: For the two clocks after the high data nibble, bus_oe_o stays 0. In the clock after those two, the host drives 4'b1111 again.
- R9: In that clock, done_o is 1 for exactly one clock, data_o equals {high nibble, low nibble} and timeout_o is 0.
- R10: With TMO_CYC=16, a ready sync in the 16th sync clock still completes the read. If all 16 sync clocks carry non-ready codes, the next clock has bus_oe_o 0. The clock after that has done_o 1, timeout_o 1 and data_o 8'h00, with the bus driven to 4'b1111.
- R11: A request raised while a cycle is running is ignored. The running cycle keeps the select and address latched at acceptance, and no extra cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request strobe, taken only when idle |
| dev_sel_i | input | 4 | Device select nibble |
| addr_i | input | ADDR_W | Byte address |
| done_o | output | 1 | One-clock completion pulse |
| data_o | output | 8 | Read byte, valid with done_o |
| timeout_o | output | 1 | Set with done_o when no ready sync arrived |
| frame_no | output | 1 | Active-low frame |
| bus_i | input | 4 | Bus nibble from the pad |
| bus_o | output | 4 | Bus nibble to the pad |
| bus_oe_o | output | 1 | Pad output enable |

## Verification
The bench uses the defaults ADDR_W=28 and TMO_CYC=16, so a full seven-nibble address and the complete wait window fit in short traces. Fifteen wait codes followed by a ready sync test the last clock that can still succeed. Sixteen wait codes test the first that times out. With a 16-clock window, every non-zero code from 1 to 15 can appear as a wait state in one trace.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SEL, ST_ADDR, ST_SIZE, ST_TAR0, ST_TAR1,
    ST_SYNC, ST_DLO, ST_DHI, ST_RTAR0, ST_RTAR1, ST_RECOV
  } fwb_state_e;

  localparam logic [3:0] NIB_START_RD = 4'b1101;
  localparam logic [3:0] NIB_READY    = 4'b0000;
  localparam logic [3:0] NIB_SIZE_1B  = 4'b0000;
  localparam logic [3:0] NIB_ONES     = 4'b1111;
endpackage

// File: rtl/fwb_nib_mux.sv
module fwb_nib_mux
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 28,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int IDX_W = $clog2(ADDR_NIBS)
) (
  input  fwb_state_e         state_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [3:0]         sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [3:0]         nib_o,
  output logic               oe_o,
  output logic               frame_no
);
  logic [3:0] addr_nib;

  always_comb begin
    addr_nib = 4'h0;
    for (int k = 0; k < ADDR_NIBS; k++) begin
      if (int'(idx_i) == k) addr_nib = addr_i[(ADDR_NIBS-1-k)*4 +: 4];
    end
  end

  always_comb begin
    nib_o    = NIB_ONES;
    oe_o     = 1'b1;
    frame_no = 1'b1;
    unique case (state_i)
      ST_START: begin nib_o = NIB_START_RD; frame_no = 1'b0; end
      ST_SEL:   nib_o = sel_i;
      ST_ADDR:  nib_o = addr_nib;
      ST_SIZE:  nib_o = NIB_SIZE_1B;
      ST_TAR1, ST_SYNC, ST_DLO, ST_DHI, ST_RTAR0, ST_RTAR1, ST_RECOV: oe_o = 1'b0;
      default:  ;
    endcase
  end
endmodule

// File: rtl/fwb_sync_timer.sv
module fwb_sync_timer #(
  parameter int TMO_CYC = 16,
  localparam int CNT_W = $clog2(TMO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ready_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && !ready_i && (cnt_q == CNT_W'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || ready_i)   cnt_q <= '0;
    else if (!expire_o)           cnt_q <= cnt_q + 1'b1;
  end

  assert_wait_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TMO_CYC));
endmodule

// File: rtl/fwb_byte_asm.sv
module fwb_byte_asm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_lo_i,
  input  logic       cap_hi_i,
  input  logic [3:0] nib_i,
  output logic [7:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_o <= '0;
    else begin
      if (cap_lo_i) byte_o[3:0] <= nib_i;
      if (cap_hi_i) byte_o[7:4] <= nib_i;
    end
  end
endmodule

// File: rtl/fwb_read_init.sv
module fwb_read_init
  import fwb_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int TMO_CYC = 16,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int IDX_W = $clog2(ADDR_NIBS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        dev_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [7:0]        data_o,
  output logic              timeout_o,
  output logic              frame_no,
  input  logic [3:0]        bus_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o
);
  fwb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ready, expire;
  logic [7:0]        rd_byte;

  assign ready = (bus_i == NIB_READY);

  fwb_nib_mux #(.ADDR_W(ADDR_W)) u_mux (
    .state_i(state_q), .idx_i(idx_q), .sel_i(sel_q), .addr_i(addr_q),
    .nib_o(bus_o), .oe_o(bus_oe_o), .frame_no(frame_no)
  );

  fwb_sync_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_SYNC),
    .ready_i(ready), .expire_o(expire)
  );

  fwb_byte_asm u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_lo_i(state_q == ST_DLO), .cap_hi_i(state_q == ST_DHI),
    .nib_i(bus_i), .byte_o(rd_byte)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_START;
      ST_START: state_d = ST_SEL;
      ST_SEL:   state_d = ST_ADDR;
      ST_ADDR:  if (idx_q == IDX_W'(ADDR_NIBS - 1)) state_d = ST_SIZE;
      ST_SIZE:  state_d = ST_TAR0;
      ST_TAR0:  state_d = ST_TAR1;
      ST_TAR1:  state_d = ST_SYNC;
      ST_SYNC:  if (ready) state_d = ST_DLO;
                else if (expire) state_d = ST_RECOV;
      ST_DLO:   state_d = ST_DHI;
      ST_DHI:   state_d = ST_RTAR0;
      ST_RTAR0: state_d = ST_RTAR1;
      ST_RTAR1: state_d = ST_IDLE;
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      sel_q     <= '0;
      addr_q    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      data_o    <= '0;
    end else begin
      state_q   <= state_d;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (state_q == ST_IDLE && req_i) begin
        sel_q  <= dev_sel_i;
        addr_q <= addr_i;
      end
      if (state_q == ST_START)     idx_q <= '0;
      else if (state_q == ST_ADDR) idx_q <= idx_q + 1'b1;
      if (state_q == ST_RTAR1) begin
        done_o <= 1'b1;
        data_o <= rd_byte;
      end else if (state_q == ST_RECOV) begin
        done_o    <= 1'b1;
        timeout_o <= 1'b1;
        data_o    <= '0;
      end
    end
  end

  assert_frame_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |=> frame_no);
  assert_tar_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) |-> $past(bus_o) == NIB_ONES);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_tmo_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && req_i) |=> ($stable(addr_q) && $stable(sel_q)));
endmodule

// File: tb/fwb_read_init_tb.sv
module fwb_read_init_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  ADDR_W = 28;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [3:0]        dev_sel_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              done_o, timeout_o, frame_no, bus_oe_o;
  logic [7:0]        data_o;
  logic [3:0]        bus_i = 4'hF;
  logic [3:0]        bus_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwb_read_init #(.ADDR_W(ADDR_W), .TMO_CYC(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .dev_sel_i(dev_sel_i),
    .addr_i(addr_i), .done_o(done_o), .data_o(data_o), .timeout_o(timeout_o),
    .frame_no(frame_no), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  typedef struct {
    logic       fr;
    logic       oe;
    logic [3:0] bus;
    logic       done;
    logic       tmo;
    logic [7:0] data;
    logic [3:0] din;
    logic       req;
    logic       poke;
  } exp_t;

  exp_t  eq[$];
  string tq[$];

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(string tag, logic fr, logic oe, logic [3:0] bus, logic done,
                      logic tmo, logic [7:0] data, logic [3:0] din, logic req, logic poke);
    exp_t e;
    e.fr = fr; e.oe = oe; e.bus = bus; e.done = done; e.tmo = tmo;
    e.data = data; e.din = din; e.req = req; e.poke = poke;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic compare(string tag, exp_t e);
    chk(tag, "frame_no", int'(frame_no), int'(e.fr));
    chk(tag, "bus_oe_o", int'(bus_oe_o), int'(e.oe));
    if (e.oe) chk(tag, "bus_o", int'(bus_o), int'(e.bus));
    chk(tag, "done_o", int'(done_o), int'(e.done));
    chk(tag, "timeout_o", int'(timeout_o), int'(e.tmo));
    if (e.done) chk(tag, "data_o", int'(data_o), int'(e.data));
  endtask

  // Reference trace of one read, then played back clock by clock.
  task automatic run_read(logic [3:0] sel, logic [ADDR_W-1:0] addr, int waits,
                          logic [3:0] lo, logic [3:0] hi, bit poke);
    exp_t e;
    string tag;
    eq.delete(); tq.delete();
    push("R1", 1, 1, 4'hF, 0, 0, 0, 4'hF, 1, 0);                // idle, request driven
    push("R2", 0, 1, 4'b1101, 0, 0, 0, 4'hF, 0, 0);             // start
    push("R3", 1, 1, sel, 0, 0, 0, 4'hF, 0, 0);                 // select
    for (int k = 0; k < ADDR_W/4; k++)                          // R4 address MSB first
      push(k == 2 && poke ? "R11" : "R4", 1, 1,
           4'((addr >> (4*(ADDR_W/4-1-k))) & 'hF), 0, 0, 0, 4'hF, 0, poke && k == 2);
    push("R5", 1, 1, 4'h0, 0, 0, 0, 4'hF, 0, 0);
    push("R6", 1, 1, 4'hF, 0, 0, 0, 4'hF, 0, 0);
    push("R6", 1, 0, 4'hF, 0, 0, 0, 4'hF, 0, 0);
    if (waits >= 16) begin
      for (int k = 0; k < 16; k++)
        push("R10", 1, 0, 4'hF, 0, 0, 0, 4'((k % 15) + 1), 0, 0);
      push("R10", 1, 0, 4'hF, 0, 0, 0, 4'hF, 0, 0);
      push("R10", 1, 1, 4'hF, 1, 1, 8'h00, 4'hF, 0, 0);
    end else begin
      for (int k = 0; k < waits; k++)
        push(waits == 15 ? "R10" : "R7", 1, 0, 4'hF, 0, 0, 0, 4'((k % 15) + 1), 0, 0);
      push("R7", 1, 0, 4'hF, 0, 0, 0, 4'h0, 0, 0);
      push("R7", 1, 0, 4'hF, 0, 0, 0, lo, 0, 0);
      push("R7", 1, 0, 4'hF, 0, 0, 0, hi, 0, 0);
      push("R8", 1, 0, 4'hF, 0, 0, 0, 4'hF, 0, 0);
      push("R8", 1, 0, 4'hF, 0, 0, 0, 4'hF, 0, 0);
      push("R9", 1, 1, 4'hF, 1, 0, {hi, lo}, 4'hF, 0, 0);
    end
    // R9/R11: pulse ends, no extra cycle follows a busy request
    push(poke ? "R11" : "R9", 1, 1, 4'hF, 0, 0, 0, 4'hF, 0, 0);
    push(poke ? "R11" : "R9", 1, 1, 4'hF, 0, 0, 0, 4'hF, 0, 0);
    for (int i = 0; i < eq.size(); i++) begin
      e = eq[i];
      tag = tq[i];
      @(negedge clk);
      bus_i     = e.din;
      req_i     = e.req | e.poke;
      dev_sel_i = e.poke ? ~sel : sel;
      addr_i    = e.poke ? ~addr : addr;
      #1;
      compare(tag, e);
    end
    req_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t idle;
    idle.fr = 1; idle.oe = 1; idle.bus = 4'hF; idle.done = 0; idle.tmo = 0;
    idle.data = 0; idle.din = 4'hF; idle.req = 0; idle.poke = 0;
    #(CLK_PERIOD*2 + 1);
    compare("R1", idle);                 // in reset
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) begin @(negedge clk); #1; compare("R1", idle); end

    run_read(4'h3, 28'h1234567, 0, 4'hA, 4'h5, 0);
    run_read(4'hC, 28'hFEDCBA9, 3, 4'h0, 4'hF, 0);
    run_read(4'h0, 28'h0F0F0F0, 15, 4'h7, 4'h2, 0);   // last clock that still completes
    run_read(4'h9, 28'h8000001, 16, 4'h1, 4'h1, 0);   // timeout
    run_read(4'h5, 28'h5A5A5A5, 1, 4'h9, 4'h6, 1);    // busy request ignored
    run_read(4'hF, 28'hFFFFFFF, 0, 4'hF, 4'hF, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule